// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Qualifier

This block sits at the front of a flash command engine. It watches an asynchronous parallel bus with a fast local clock. The bus has three active-low controls (chip select, write enable, output enable) and carries a 20-bit address and 16-bit data. The block decides when a real write cycle takes place. For each accepted cycle it gives the command engine one single-clock strobe, together with the captured address and data.

All bus controls pass through a multi-flop synchronizer and then a run-length filter. A level change on a control is accepted only after it has been seen for `FILT_LEN` consecutive clocks, so short noise pulses are dropped. The address is taken when the second of chip select and write enable goes low, which opens the cycle. The data is taken when the first of the two goes high, which closes the cycle. The address and data buses are delayed by the same number of clocks as the filter. The captured values therefore belong to the clock in which the edge first appeared.

While the supply-good input is low, the block holds the command engine in reset and drops all writes. After power returns, it stays locked until chip select or write enable has been seen high. This stops a bus that was already parked in a write state from producing a command.

Top module: `pbw_write_qualifier`

## Requirements
- R1: `wr_stb` is never high for two clocks in a row; each accepted write cycle produces exactly one strobe.
- R2: A write cycle is open only while filtered chip select and write enable are both low and filtered output enable is high. No strobe is produced otherwise.
- R3: `wr_addr` carries the address that was on the bus in the clock where the later of the two falling edges (chip select, write enable) was first sampled.
- R4: The strobe is issued when the earlier of the two rising edges (chip select, write enable) passes the filter. `wr_data` carries the data that was on the bus in the clock where that rising edge was first sampled.
- R5: If output enable goes low while a cycle is open, the cycle is dropped and no strobe follows.
- R6: A level on any control that lasts fewer than `FILT_LEN` (default 4) consecutive clock samples neither opens nor closes a cycle.
- R7: While `pwr_ok` is low, `eng_rst` is high, no strobe is issued, and any open cycle is dropped.
- R8: After `pwr_ok` rises (and after reset), no cycle is accepted until filtered chip select or write enable has been high at least once. A bus parked in the write state at power-up therefore yields no strobe when write enable rises.
- R9: `wr_addr` and `wr_data` change only in the clock where `wr_stb` is high.
- R10: In reset, `wr_stb` is 0, `eng_rst` is 1, and `wr_addr` and `wr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply above the write lockout level (asynchronous) |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_addr | input | AW (20) | Bus address |
| bus_data | input | DW (16) | Bus write data |
| wr_stb | output | 1 | One-clock write strobe to the command engine |
| wr_addr | output | AW (20) | Captured address, valid with and held after `wr_stb` |
| wr_data | output | DW (16) | Captured data, valid with and held after `wr_stb` |
| eng_rst | output | 1 | Reset to the command engine while supply is low |

## Verification
A wrong lockout or cycle-open flag shows at the ports as a missing or extra strobe, about `FILT_LEN`+2 clocks after the bus edge that closes the cycle. A delay line or filter counter that is off by one shows as the wrong address or data word in the strobe cycle, or as a strobe that comes one clock early or late. The bench follows a behavioural model clock by clock, so either fault is reported in the cycle in which it first shows.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

   // bit positions of the synchronized control vector
   localparam int CTL_CS  = 0;
   localparam int CTL_WE  = 1;
   localparam int CTL_OE  = 2;
   localparam int CTL_PWR = 3;
   localparam int CTL_W   = 4;
   localparam int FLT_W   = 3;

   // conservative reset image: cycle-like controls, supply not good
   localparam logic [CTL_W-1:0] CTL_RST = 4'b0100;
   localparam logic [FLT_W-1:0] FLT_RST = 3'b100;

   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pbw_sync.sv
module pbw_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[k] <= RST_VAL;
               else        stg[k] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[k] <= RST_VAL;
               else        stg[k] <= stg[k-1];
            end
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/pbw_filter.sv
module pbw_filter #(
   parameter int           W       = 3,
   parameter int           FILT    = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   import pbw_pkg::*;

   localparam int              CW       = cnt_width(FILT);
   localparam logic [CW-1:0]   CNT_LAST = CW'(FILT - 1);

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic [CW-1:0] run;
         logic          lvl;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl <= RST_VAL[i];
               run <= '0;
            end else if (din[i] == lvl) begin
               run <= '0;
            end else if (run == CNT_LAST) begin
               lvl <= din[i];
               run <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end

         assign dout[i] = lvl;
      end
   endgenerate

endmodule

// File: rtl/pbw_delay.sv
module pbw_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (DEPTH == 0) begin : g_pass
         assign dout = din;
      end else begin : g_line
         logic [W-1:0] tap [DEPTH];
         for (genvar k = 0; k < DEPTH; k++) begin : g_tap
            if (k == 0) begin : g_head
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) tap[k] <= '0;
                  else        tap[k] <= din;
               end
            end else begin : g_body
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) tap[k] <= '0;
                  else        tap[k] <= tap[k-1];
               end
            end
         end
         assign dout = tap[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/pbw_fsm.sv
module pbw_fsm #(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_s,
   input  logic          cs_f,
   input  logic          we_f,
   input  logic          oe_f,
   input  logic [AW-1:0] addr_d,
   input  logic [DW-1:0] data_d,
   output logic          wr_stb,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          eng_rst,
   output logic          lock_q
);

   logic          open_q;
   logic [AW-1:0] addr_q;
   logic          sel_act;
   logic          released;

   assign sel_act  = !lock_q && !cs_f && !we_f && oe_f;
   assign released = cs_f || we_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b1;
         open_q  <= 1'b0;
         addr_q  <= '0;
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         eng_rst <= 1'b1;
      end else begin
         eng_rst <= !pwr_s;
         wr_stb  <= 1'b0;
         if (!pwr_s) begin
            lock_q <= 1'b1;
            open_q <= 1'b0;
         end else begin
            if (lock_q && released) lock_q <= 1'b0;
            if (!open_q && sel_act) begin
               open_q <= 1'b1;
               addr_q <= addr_d;
            end else if (open_q && !sel_act) begin
               open_q <= 1'b0;
               if (released && oe_f) begin
                  wr_stb  <= 1'b1;
                  wr_addr <= addr_q;
                  wr_data <= data_d;
               end
            end
         end
      end
   end

endmodule

// File: rtl/pbw_write_qualifier.sv
module pbw_write_qualifier #(
   parameter int AW          = 20,
   parameter int DW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_ok,
   input  logic          bus_cs_n,
   input  logic          bus_we_n,
   input  logic          bus_oe_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_data,
   output logic          wr_stb,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          eng_rst
);
   import pbw_pkg::*;

   localparam int BW = AW + DW;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
      if (AW < 1 || DW < 1) begin : g_bad_bus
         $error("bus widths must be positive");
      end
   endgenerate

   logic [CTL_W-1:0] ctl_raw, ctl_s;
   logic [FLT_W-1:0] flt;
   logic [BW-1:0]    bus_s, bus_d;
   logic             cs_f, we_f, oe_f;
   logic             lock_q;

   assign ctl_raw = {pwr_ok, bus_oe_n, bus_we_n, bus_cs_n};

   pbw_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .din(ctl_raw), .dout(ctl_s)
   );

   pbw_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .din({bus_addr, bus_data}), .dout(bus_s)
   );

   pbw_filter #(.W(FLT_W), .FILT(FILT_LEN), .RST_VAL(FLT_RST)) u_filter (
      .clk(clk), .rst_n(rst_n), .din(ctl_s[FLT_W-1:0]), .dout(flt)
   );

   // align address/data with the filter's acceptance latency
   pbw_delay #(.W(BW), .DEPTH(FILT_LEN)) u_align (
      .clk(clk), .rst_n(rst_n), .din(bus_s), .dout(bus_d)
   );

   assign cs_f = flt[CTL_CS];
   assign we_f = flt[CTL_WE];
   assign oe_f = flt[CTL_OE];

   pbw_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_s   (ctl_s[CTL_PWR]),
      .cs_f    (cs_f),
      .we_f    (we_f),
      .oe_f    (oe_f),
      .addr_d  (bus_d[BW-1:DW]),
      .data_d  (bus_d[DW-1:0]),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .eng_rst (eng_rst),
      .lock_q  (lock_q)
   );

endmodule

// File: rtl/pbw_write_qualifier_chk.sv
module pbw_write_qualifier_chk #(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_stb,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          eng_rst,
   input logic          cs_f,
   input logic          we_f,
   input logic          oe_f,
   input logic          lock_q
);

   p_one_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   p_close_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(cs_f || we_f));

   p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(oe_f));

   p_quiet_in_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst |-> !wr_stb);

   p_locked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> !wr_stb);

   p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));

endmodule

bind pbw_write_qualifier pbw_write_qualifier_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_stb  (wr_stb),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .eng_rst (eng_rst),
   .cs_f    (cs_f),
   .we_f    (we_f),
   .oe_f    (oe_f),
   .lock_q  (lock_q)
);

// File: tb/tb_pbw_write_qualifier.sv
`timescale 1ns/1ps
module tb_pbw_write_qualifier;

   localparam int AW   = 20;
   localparam int DW   = 16;
   localparam int FILT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwr_ok = 1'b0;
   logic          cs_n = 1'b0, we_n = 1'b0, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic          wr_stb, eng_rst;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   int checks = 0;
   int errors = 0;
   int nstb   = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pbw_write_qualifier #(.AW(AW), .DW(DW), .SYNC_STAGES(2), .FILT_LEN(FILT)) dut (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
      .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
      .bus_addr(addr), .bus_data(data),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .eng_rst(eng_rst)
   );

   // ---------------- behavioural reference model ----------------
   // index 0 cs, 1 we, 2 oe, 3 supply
   bit            s1 [4], s2 [4], fl [3];
   int            run [3];
   logic [AW-1:0] a1, a2, aq, m_wa;
   logic [DW-1:0] d1, d2, m_wd;
   logic [AW-1:0] adq [$];
   logic [DW-1:0] ddq [$];
   bit            m_lock, m_open, m_stb, m_eng;

   task automatic model_reset();
      s1 = '{0, 0, 1, 0}; s2 = '{0, 0, 1, 0};
      fl = '{0, 0, 1};
      run = '{0, 0, 0};
      a1 = '0; a2 = '0; d1 = '0; d2 = '0; aq = '0; m_wa = '0; m_wd = '0;
      adq.delete(); ddq.delete();
      for (int k = 0; k < FILT; k++) begin adq.push_back('0); ddq.push_back('0); end
      m_lock = 1; m_open = 0; m_stb = 0; m_eng = 1;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit act, rel;
         act = !m_lock && !fl[0] && !fl[1] && fl[2];
         rel = fl[0] || fl[1];
         m_eng = !s2[3];
         m_stb = 0;
         if (!s2[3]) begin
            m_lock = 1; m_open = 0;
         end else begin
            if (m_lock && rel) m_lock = 0;
            if (!m_open && act) begin
               m_open = 1; aq = adq[FILT-1];
            end else if (m_open && !act) begin
               m_open = 0;
               if (rel && fl[2]) begin
                  m_stb = 1; m_wa = aq; m_wd = ddq[FILT-1];
               end
            end
         end
         for (int i = 0; i < 3; i++) begin
            if (s2[i] == fl[i]) run[i] = 0;
            else if (run[i] == FILT - 1) begin fl[i] = s2[i]; run[i] = 0; end
            else run[i] = run[i] + 1;
         end
         adq.push_front(a2); void'(adq.pop_back());
         ddq.push_front(d2); void'(ddq.pop_back());
         a2 = a1; d2 = d1; a1 = addr; d1 = data;
         s2 = s1;
         s1 = '{cs_n, we_n, oe_n, pwr_ok};
      end
   end

   // ---------------- per-clock comparison ----------------
   bit prev_stb = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (wr_stb !== m_stb || eng_rst !== m_eng ||
             wr_addr !== m_wa || wr_data !== m_wd) begin
            errors++;
            $display("FAIL R2 model mismatch act stb=%0b rst=%0b a=%h d=%h exp stb=%0b rst=%0b a=%h d=%h",
                     wr_stb, eng_rst, wr_addr, wr_data, m_stb, m_eng, m_wa, m_wd);
         end
         if (wr_stb) begin
            nstb++;
            checks++;
            if (prev_stb) begin
               errors++;
               $display("FAIL R1 strobe wider than one clock act=1 exp=0");
            end
         end
         prev_stb = wr_stb;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_strobes(input int base, input int n, input string tag);
      chk(nstb - base == n, tag, nstb - base, n);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int base;
      tick(3);
      // R10: reset values while reset is held
      chk(wr_stb == 0 && eng_rst == 1 && wr_addr == 0 && wr_data == 0,
          "R10 reset outputs", {wr_stb, eng_rst}, 2'b01);
      rst_n = 1'b1;
      tick(3);
      chk(eng_rst == 1, "R7 engine reset while supply low", eng_rst, 1);

      // R8: bus parked in write state at power-up
      base = nstb;
      addr = 20'h11111; data = 16'h1111;
      pwr_ok = 1'b1; tick(12);
      chk(eng_rst == 0, "R7 engine reset released", eng_rst, 0);
      we_n = 1'b1; tick(12);
      expect_strobes(base, 0, "R8 parked write rejected");
      base = nstb;
      we_n = 1'b0; tick(12); we_n = 1'b1; tick(12);
      expect_strobes(base, 1, "R8 lock released after high level");
      cs_n = 1'b1; tick(10);

      // R3/R4: write-enable controlled cycle
      base = nstb;
      addr = 20'hA1A1A; cs_n = 1'b0; tick(10);
      addr = 20'hA2A2A; tick(2);
      we_n = 1'b0; tick(10);
      data = 16'hD1D1; tick(10);
      we_n = 1'b1; tick(3);
      data = 16'hD2D2; addr = 20'h00000; tick(10);
      cs_n = 1'b1; tick(12);
      expect_strobes(base, 1, "R4 one strobe per cycle");
      chk(wr_addr == 20'hA2A2A, "R3 address at later fall", wr_addr, 20'hA2A2A);
      chk(wr_data == 16'hD1D1, "R4 data at earlier rise", wr_data, 16'hD1D1);

      // R3/R4: chip-select controlled cycle
      base = nstb;
      addr = 20'h33333; we_n = 1'b0; tick(10);
      addr = 20'h44444; tick(2);
      cs_n = 1'b0; tick(8);
      data = 16'h3C3C; tick(8);
      cs_n = 1'b1; tick(3);
      data = 16'hFFFF; tick(10);
      we_n = 1'b1; tick(12);
      expect_strobes(base, 1, "R4 chip-select closes cycle");
      chk(wr_addr == 20'h44444, "R3 address at chip-select fall", wr_addr, 20'h44444);
      chk(wr_data == 16'h3C3C, "R4 data at chip-select rise", wr_data, 16'h3C3C);

      // R2/R5: output enable low inhibits or drops a cycle
      base = nstb;
      oe_n = 1'b0; cs_n = 1'b0; we_n = 1'b0; tick(12);
      we_n = 1'b1; cs_n = 1'b1; tick(12);
      oe_n = 1'b1; tick(10);
      expect_strobes(base, 0, "R2 output enable low inhibits");
      base = nstb;
      cs_n = 1'b0; we_n = 1'b0; tick(12);
      oe_n = 1'b0; tick(12);
      we_n = 1'b1; cs_n = 1'b1; tick(12);
      oe_n = 1'b1; tick(10);
      expect_strobes(base, 0, "R5 output enable drop cancels cycle");

      // R6: short pulses rejected
      base = nstb;
      cs_n = 1'b0; tick(10);
      we_n = 1'b0; tick(FILT - 1); we_n = 1'b1; tick(12);
      cs_n = 1'b1; tick(10);
      expect_strobes(base, 0, "R6 short write pulse ignored");
      base = nstb;
      data = 16'h5A5A;
      cs_n = 1'b0; we_n = 1'b0; tick(12);
      we_n = 1'b1; tick(FILT - 1); we_n = 1'b0; tick(12);
      we_n = 1'b1; tick(12); cs_n = 1'b1; tick(10);
      expect_strobes(base, 1, "R6 short high glitch does not split cycle");
      chk(wr_data == 16'h5A5A, "R6 data after glitch", wr_data, 16'h5A5A);

      // R7: supply drop during an open cycle
      base = nstb;
      cs_n = 1'b0; we_n = 1'b0; tick(12);
      pwr_ok = 1'b0; tick(5);
      chk(eng_rst == 1, "R7 engine reset on supply drop", eng_rst, 1);
      we_n = 1'b1; cs_n = 1'b1; tick(12);
      expect_strobes(base, 0, "R7 no strobe with supply low");
      pwr_ok = 1'b1; tick(12);
      base = nstb;
      data = 16'h7777; cs_n = 1'b0; we_n = 1'b0; tick(12);
      we_n = 1'b1; cs_n = 1'b1; tick(12);
      expect_strobes(base, 1, "R7 writes resume after supply returns");

      // random traffic, compared with the model every clock (R1..R9)
      for (int n = 0; n < 120; n++) begin
         addr = AW'($urandom); data = DW'($urandom);
         oe_n = ($urandom_range(0, 7) == 0);
         if ($urandom_range(0, 1)) cs_n = 1'b0; else we_n = 1'b0;
         tick($urandom_range(1, 6));
         addr = AW'($urandom);
         cs_n = 1'b0; we_n = 1'b0;
         tick($urandom_range(1, 10));
         data = DW'($urandom);
         if ($urandom_range(0, 1)) cs_n = 1'b1; else we_n = 1'b1;
         tick($urandom_range(1, 6));
         data = DW'($urandom);
         cs_n = 1'b1; we_n = 1'b1;
         if ($urandom_range(0, 15) == 0) begin pwr_ok = 1'b0; tick(4); pwr_ok = 1'b1; end
         tick($urandom_range(1, 10));
      end
      tick(20);

      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule